// File: doc/BRIEF.md
# Receive FIFO Flow-Control Hysteresis Controller

This block drives an active-low request-to-send line from the fill level of a 64-entry receive FIFO. A 2-bit table select picks one of four sets of receive trigger levels. A 2-bit index picks the programmed trigger within that set.

For tables A, B and C the line does not switch at the programmed trigger. The block tells the far sender to stop once the FIFO count reaches the table entry one step above the trigger. It lets the sender resume once the count has drained to the entry one step below the trigger. The gap between those two thresholds keeps the line from chattering while the count hovers near one value. Table D has no gap: it switches at the programmed trigger itself.

The stop/resume decision is kept in one flag register. That flag is updated on each clock edge and drives the output directly. While automatic flow control is disabled, and after reset, the line stays asserted (low) whatever the count is.

Top module: `rts_hyst_ctrl`

## Requirements
- R1: After reset `rts_n` is 0 (the sender may transmit).
- R2: While `auto_en` is 0, `rts_n` is 0 one clock after that sample, whatever `fifo_count` is. This includes the case where the line was high just before.
- R3: With table A, B or C and `auto_en` 1, a count at or above the entry one index above `trig_sel` drives `rts_n` to 1 one clock later.
- R4: With table A, B or C and `auto_en` 1, a count at or below the entry one index below `trig_sel` drives `rts_n` to 0 one clock later.
- R5: With table A, B or C, a count strictly between the two thresholds leaves `rts_n` unchanged.
- R6: With `trig_sel` 3 the upper threshold is the FIFO depth (64). With `trig_sel` 0 the lower threshold is 0.
- R7: With table D (`tbl_sel` 3), `rts_n` goes to 1 when the count is at or above the selected entry. It goes to 0 when the count is below that entry.
- R8: Table encodings on `tbl_sel`, with `trig_sel` 0..3 picking entries in ascending order:
  - 0 = A {1, 4, 8, 14}
  - 1 = B {8, 16, 24, 28}
  - 2 = C {8, 16, 56, 60}
  - 3 = D {4, 16, 32, 48}
- R9: `rts_n` changes only at a rising clock edge. A new input shows at the output after exactly one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| auto_en | input | 1 | Automatic flow-control enable |
| tbl_sel | input | 2 | Trigger table select (A..D) |
| trig_sel | input | 2 | Programmed receive trigger index |
| fifo_count | input | 7 | Current receive FIFO fill level, 0..64 |
| rts_n | output | 1 | Request-to-send, active low (1 = stop sender) |

## Verification
The assertions assume that `fifo_count` never exceeds the FIFO depth. They also assume that the table and trigger selects only change while the block is in a steady state the checks can attribute, because the hold rule is stated against the thresholds decoded in the same cycle. The stimulus changes one input at a time on the falling edge. It keeps every count in 0..64 and steps the count across each threshold from both sides.

// File: rtl/rts_hyst_pkg.sv
package rts_hyst_pkg;

   localparam int unsigned NUM_TABLES = 4;
   localparam int unsigned NUM_LEVELS = 4;

   typedef enum logic [1:0] {
      TBL_A = 2'd0,
      TBL_B = 2'd1,
      TBL_C = 2'd2,
      TBL_D = 2'd3
   } tbl_sel_e;

   // Receive trigger level for table t, ascending index i.
   function automatic int unsigned trig_level(input int unsigned t, input int unsigned i);
      int unsigned lvl;
      case (t)
         0: case (i) 0: lvl = 1; 1: lvl = 4;  2: lvl = 8;  default: lvl = 14; endcase
         1: case (i) 0: lvl = 8; 1: lvl = 16; 2: lvl = 24; default: lvl = 28; endcase
         2: case (i) 0: lvl = 8; 1: lvl = 16; 2: lvl = 56; default: lvl = 60; endcase
         default: case (i) 0: lvl = 4; 1: lvl = 16; 2: lvl = 32; default: lvl = 48; endcase
      endcase
      return lvl;
   endfunction

   // True when table t switches with a gap between stop and resume.
   function automatic bit uses_gap(input int unsigned t);
      return t != 3;
   endfunction

endpackage

// File: rtl/rts_thr_decode.sv
module rts_thr_decode
   import rts_hyst_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [1:0]       tbl_sel,
   input  logic [1:0]       trig_sel,
   output logic [CNT_W-1:0] upper_thr,
   output logic [CNT_W-1:0] lower_thr
);

   logic [CNT_W-1:0] up_lut [NUM_TABLES][NUM_LEVELS];
   logic [CNT_W-1:0] lo_lut [NUM_TABLES][NUM_LEVELS];

   for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
      for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_lvl
         localparam int unsigned SELF = trig_level(t, i);
         if (uses_gap(t)) begin : g_gap
            localparam int unsigned UP = (i == NUM_LEVELS - 1) ? DEPTH : trig_level(t, i + 1);
            localparam int unsigned LO = (i == 0) ? 0 : trig_level(t, i - 1);
            assign up_lut[t][i] = CNT_W'(UP);
            assign lo_lut[t][i] = CNT_W'(LO);
         end else begin : g_direct
            assign up_lut[t][i] = CNT_W'(SELF);
            assign lo_lut[t][i] = CNT_W'(SELF - 1);
         end
      end
   end

   always_comb begin
      upper_thr = up_lut[tbl_sel][trig_sel];
      lower_thr = lo_lut[tbl_sel][trig_sel];
   end

endmodule

// File: rtl/rts_hyst_flag.sv
module rts_hyst_flag #(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auto_en,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] upper_thr,
   input  logic [CNT_W-1:0] lower_thr,
   output logic             stop_q
);

   logic stop_d;

   always_comb begin
      stop_d = stop_q;
      if (!auto_en)
         stop_d = 1'b0;
      else if (count >= upper_thr)
         stop_d = 1'b1;
      else if (count <= lower_thr)
         stop_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stop_q <= 1'b0;
      else        stop_q <= stop_d;
   end

endmodule

// File: rtl/rts_hyst_ctrl.sv
module rts_hyst_ctrl
   import rts_hyst_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auto_en,
   input  logic [1:0]       tbl_sel,
   input  logic [1:0]       trig_sel,
   input  logic [CNT_W-1:0] fifo_count,
   output logic             rts_n
);

   if (DEPTH <= 60) begin : g_bad_depth
      $error("rts_hyst_ctrl: DEPTH must exceed the highest table entry (60)");
   end

   logic [CNT_W-1:0] upper_thr;
   logic [CNT_W-1:0] lower_thr;
   logic             stop_q;

   rts_thr_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_decode (
      .tbl_sel   (tbl_sel),
      .trig_sel  (trig_sel),
      .upper_thr (upper_thr),
      .lower_thr (lower_thr)
   );

   rts_hyst_flag #(.CNT_W(CNT_W)) u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .auto_en   (auto_en),
      .count     (fifo_count),
      .upper_thr (upper_thr),
      .lower_thr (lower_thr),
      .stop_q    (stop_q)
   );

   assign rts_n = stop_q;

endmodule

// File: rtl/rts_hyst_checker.sv
module rts_hyst_checker #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             auto_en,
   input logic [CNT_W-1:0] fifo_count,
   input logic [CNT_W-1:0] upper_thr,
   input logic [CNT_W-1:0] lower_thr,
   input logic             rts_n
);

   assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= CNT_W'(DEPTH));

   assert_thr_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      upper_thr > lower_thr && upper_thr <= CNT_W'(DEPTH));

   assert_disabled_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en |=> !rts_n);

   assert_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && fifo_count >= upper_thr) |=> rts_n);

   assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && fifo_count <= lower_thr) |=> !rts_n);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && fifo_count > lower_thr && fifo_count < upper_thr) |=> $stable(rts_n));

endmodule

bind rts_hyst_ctrl rts_hyst_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .auto_en    (auto_en),
   .fifo_count (fifo_count),
   .upper_thr  (upper_thr),
   .lower_thr  (lower_thr),
   .rts_n      (rts_n)
);

// File: tb/rts_hyst_ctrl_tb.sv
module rts_hyst_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       auto_en = 1'b0;
   logic [1:0] tbl_sel = 2'd0;
   logic [1:0] trig_sel = 2'd0;
   logic [6:0] fifo_count = 7'd0;
   logic       rts_n;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   rts_hyst_ctrl dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .auto_en    (auto_en),
      .tbl_sel    (tbl_sel),
      .trig_sel   (trig_sel),
      .fifo_count (fifo_count),
      .rts_n      (rts_n)
   );

   task automatic check(input logic exp, input string req);
      n_tests++;
      if (rts_n !== exp) begin
         n_fail++;
         $display("FAIL %s: rts_n=%0b expected %0b", req, rts_n, exp);
      end
   endtask

   // Drive a count on a falling edge, sample at the next falling edge.
   task automatic step(input int cnt, input logic exp, input string req);
      @(negedge clk);
      fifo_count = 7'(cnt);
      @(negedge clk);
      check(exp, req);
   endtask

   task automatic setup(input int tbl, input int idx);
      @(negedge clk);
      auto_en    = 1'b0;
      tbl_sel    = 2'(tbl);
      trig_sel   = 2'(idx);
      fifo_count = 7'd0;
      @(negedge clk);
      auto_en = 1'b1;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(1'b0, "R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(1'b0, "R1 after reset");
   endtask

   task automatic t_table_c;
      setup(2, 2);                      // upper 60, lower 16
      step(59, 1'b0, "R5 C below upper");
      step(60, 1'b1, "R3 C stop at 60");
      step(30, 1'b1, "R5 C hold high");
      step(17, 1'b1, "R5 C hold at 17");
      step(16, 1'b0, "R4 C resume at 16");
      step(40, 1'b0, "R5 C hold low");
   endtask

   task automatic t_table_a_ends;
      setup(0, 0);                      // upper 4, lower 0
      step(4, 1'b1, "R8 A idx0 stop at 4");
      step(1, 1'b1, "R6 A idx0 hold at 1");
      step(0, 1'b0, "R6 A idx0 resume at 0");
      setup(0, 1);                      // upper 8, lower 1
      step(7, 1'b0, "R8 A idx1 below 8");
      step(8, 1'b1, "R8 A idx1 stop at 8");
      step(2, 1'b1, "R8 A idx1 hold at 2");
      step(1, 1'b0, "R8 A idx1 resume at 1");
   endtask

   task automatic t_table_b_top;
      setup(1, 3);                      // upper 64, lower 24
      step(63, 1'b0, "R6 B idx3 below 64");
      step(64, 1'b1, "R6 B idx3 stop at 64");
      step(25, 1'b1, "R5 B hold at 25");
      step(24, 1'b0, "R4 B resume at 24");
   endtask

   task automatic t_table_d;
      setup(3, 1);                      // trigger 16
      step(15, 1'b0, "R7 D below 16");
      step(16, 1'b1, "R7 D stop at 16");
      step(15, 1'b0, "R7 D resume at 15");
   endtask

   task automatic t_disable;
      setup(2, 1);                      // upper 56
      step(56, 1'b1, "R3 C idx1 stop at 56");
      @(negedge clk);
      auto_en = 1'b0;
      @(negedge clk);
      check(1'b0, "R2 disable releases");
      step(64, 1'b0, "R2 disabled ignores full count");
   endtask

   task automatic t_latency;
      setup(2, 2);
      @(negedge clk);
      fifo_count = 7'd60;
      #1;
      check(1'b0, "R9 no change before edge");
      @(posedge clk);
      #1;
      check(1'b1, "R9 change after one edge");
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_table_c();
            t_table_a_ends();
            t_table_b_top();
            t_table_d();
            t_disable();
            t_latency();
         end
         begin
            repeat (5000) @(posedge clk);
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule